// File: doc/BRIEF.md
# Six-Channel Staged-Update PWM Controller

This block drives six pulse-width modulated pins from a small register file that is read and written over a single-cycle bus. Each channel has its own clock divider, a 24-bit period count and a 24-bit high-time count. Each channel also has a polarity bit that picks the active level, and a mode bit that picks between a repeating waveform and a single period after each commit.

New divider, period and high-time values do not reach the waveform when they are written. They go into shadow registers. Software moves them into the running copy with a two-bit handshake per channel. It first raises the channel's staging bit and drops its trigger bit, then writes the shadow values. A final control write then drops staging and raises trigger. A trigger rise that follows a raised staging bit waits for the running period to finish, so the pin never shows a truncated or stretched pulse. A trigger rise without staging restarts the channel on the next clock. Committing a period and high time of zero parks the pin at its inactive level.

Top module: `pwm_stage_top`

## Requirements
- R1: After reset every register reads zero, and every pin is high, which is the inactive level for polarity 0.
- R2: Register map, 32-bit words. Control is at 0x00, with trigger at bit ch, polarity at bit 8+ch, mode at bit 16+ch and staging at bit 24+ch. The divider register is at 0x04, with a 3-bit field at bit 4*ch. Period is at 0x08+8*ch and high time is at 0x0C+8*ch, each 24 bits. Reads return the last written value in defined bits and zero in all other bits and at all other addresses.
- R3: The channel count advances once every (divider+1) clocks.
- R4: The count runs from 0 to period-1. With polarity 1 the pin is high while the count is below the high time and low otherwise; polarity 0 inverts this. A high time at or above the period gives a fully active pin.
- R5: Writes to the divider, period or high-time registers leave the pin unchanged until a commit.
- R6: A control write that raises a trigger bit while that channel's staging bit was 0 commits on that write's clock edge E. After edge E+1+t the pin shows the level for count floor(t/(divider+1)) mod period.
- R7: A control write that raises a trigger bit while that channel's staging bit was 1 (its value before the write) keeps the old waveform to the end of the running period. The new settings start from count zero at that boundary.
- R8: A channel whose committed period is below 2 holds its pin at the inactive level (the inverse of its polarity). A staged commit on such a channel takes effect at once.
- R9: With mode 1 the waveform repeats. With mode 0 the channel runs one period after a commit and then holds the inactive level until the next commit.
- R10: Writing a trigger bit as 1 when it already reads 1 does not commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_sel |
| pwm_out | output | 6 | One PWM pin per channel |

## Verification
The embedded properties assume the following about the inputs:
- At most one bus access happens per cycle, at a word-aligned address.
- Control writes are the only source of commits.
- The running divider changes only when the channel restarts.

The stimulus keeps to these assumptions. Inputs change only on falling clock edges. Each write is followed by an idle cycle, so every commit edge is known exactly. The staged cases raise the staging bit in a write of its own, before the write that raises the trigger, as the handshake requires.

// File: rtl/pwm_stage_pkg.sv
package pwm_stage_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // control word: one bit group per channel, group base positions
   localparam int unsigned CTL_TRIG_LSB   = 0;
   localparam int unsigned CTL_POL_LSB    = 8;
   localparam int unsigned CTL_MODE_LSB   = 16;
   localparam int unsigned CTL_STAGE_LSB  = 24;
   localparam int unsigned CTL_GROUP_MAX  = 8;

   // byte map
   localparam int unsigned MAP_CTRL       = 'h00;
   localparam int unsigned MAP_DIV        = 'h04;
   localparam int unsigned MAP_CH_BASE    = 'h08;
   localparam int unsigned MAP_CH_STRIDE  = 8;
   localparam int unsigned MAP_HI_OFS     = 4;
   localparam int unsigned DIV_FIELD_STEP = 4;

   localparam int unsigned BUS_W          = 32;
endpackage

// File: rtl/pwm_stage_presc.sv
module pwm_stage_presc #(
   parameter int unsigned PRE_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             hold,
   input  logic [PRE_W-1:0] limit,
   output logic             tick
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [PRE_W-1:0] pcnt;

   always_ff @(posedge clk) begin
      if (!rst_n)              pcnt <= '0;
      else if (restart | hold) pcnt <= '0;
      else if (pcnt == limit)  pcnt <= '0;
      else                     pcnt <= pcnt + PRE_W'(1);
   end

   assign tick = !hold && (pcnt == limit);

   AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt <= limit); // R3
endmodule

// File: rtl/pwm_stage_chan.sv
module pwm_stage_chan #(
   parameter int unsigned CNT_W = 24,
   parameter int unsigned PRE_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] sh_pre,
   input  logic [CNT_W-1:0] sh_per,
   input  logic [CNT_W-1:0] sh_hi,
   input  logic             pol,
   input  logic             mode,
   input  logic             commit_now,
   input  logic             commit_defer,
   output logic             pwm_out
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [PRE_W-1:0] act_pre;
   logic [CNT_W-1:0] act_per, act_hi, cnt;
   logic             done_q, pend_q, out_q;
   logic             tick, idle, period_end, load;

   assign idle       = (act_per < CNT_W'(2)) | done_q;
   assign period_end = tick & (cnt == act_per - CNT_W'(1));
   assign load       = commit_now | ((commit_defer | pend_q) & (idle | period_end));

   pwm_stage_presc #(.PRE_W(PRE_W)) u_presc (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(load),
      .hold   (idle),
      .limit  (act_pre),
      .tick   (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_pre <= '0;
         act_per <= '0;
         act_hi  <= '0;
         cnt     <= '0;
         done_q  <= 1'b0;
         pend_q  <= 1'b0;
      end else if (load) begin
         act_pre <= sh_pre;
         act_per <= sh_per;
         act_hi  <= sh_hi;
         cnt     <= '0;
         done_q  <= 1'b0;
         pend_q  <= 1'b0;
      end else begin
         if (commit_defer) pend_q <= 1'b1;
         if (tick) begin
            if (cnt == act_per - CNT_W'(1)) begin
               cnt <= '0;
               if (!mode) done_q <= 1'b1;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

   // registered pin: level follows the count of the previous cycle
   always_ff @(posedge clk) begin
      if (!rst_n)    out_q <= 1'b1;   // inactive level of reset polarity 0
      else if (idle) out_q <= ~pol;
      else            out_q <= (cnt < act_hi) ? pol : ~pol;
   end

   assign pwm_out = out_q;

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |-> (cnt < act_per)); // R4
   AST_IDLE_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> (pwm_out == !$past(pol))); // R8
   AST_PEND_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !idle); // R7
endmodule

// File: rtl/pwm_stage_top.sv
module pwm_stage_top #(
   parameter int unsigned CHANNELS = 6,
   parameter int unsigned CNT_W    = 24,
   parameter int unsigned PRE_W    = 3,
   parameter int unsigned ADDR_W   = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_sel,
   input  logic                bus_we,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic [CHANNELS-1:0] pwm_out
);
   timeunit 1ns;
   timeprecision 1ps;
   import pwm_stage_pkg::*;

   localparam logic [31:0] GRP_ONES  = 32'((64'd1 << CHANNELS) - 64'd1);
   localparam logic [31:0] CTRL_MASK = (GRP_ONES << CTL_TRIG_LSB) | (GRP_ONES << CTL_POL_LSB)
                                     | (GRP_ONES << CTL_MODE_LSB) | (GRP_ONES << CTL_STAGE_LSB);
   localparam int unsigned MAP_END   = MAP_CH_BASE + MAP_CH_STRIDE * CHANNELS;

   if (CHANNELS < 1 || CHANNELS > CTL_GROUP_MAX) begin : g_bad_channels
      $error("CHANNELS must lie in 1..8");
   end
   if (PRE_W < 1 || PRE_W > DIV_FIELD_STEP) begin : g_bad_pre
      $error("PRE_W must lie in 1..4");
   end
   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt
      $error("CNT_W must lie in 2..32");
   end
   if (MAP_END > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic                wr_en, ctrl_hit, div_hit;
   logic [31:0]         ctrl_q;
   logic [PRE_W-1:0]    div_sh [CHANNELS];
   logic [CNT_W-1:0]    per_sh [CHANNELS];
   logic [CNT_W-1:0]    hi_sh  [CHANNELS];
   logic [CHANNELS-1:0] c_now, c_defer;
   logic                wdata_unused;

   assign wr_en        = bus_sel & bus_we;
   assign ctrl_hit     = wr_en && (bus_addr == ADDR_W'(MAP_CTRL));
   assign div_hit      = wr_en && (bus_addr == ADDR_W'(MAP_DIV));
   assign wdata_unused = ^bus_wdata;

   always_ff @(posedge clk) begin
      if (!rst_n)        ctrl_q <= '0;
      else if (ctrl_hit) ctrl_q <= bus_wdata & CTRL_MASK;
   end

   for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
      localparam logic [ADDR_W-1:0] PER_A = ADDR_W'(MAP_CH_BASE + MAP_CH_STRIDE * ch);
      localparam logic [ADDR_W-1:0] HI_A  = ADDR_W'(MAP_CH_BASE + MAP_CH_STRIDE * ch + MAP_HI_OFS);
      logic trig_rise;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            div_sh[ch] <= '0;
            per_sh[ch] <= '0;
            hi_sh[ch]  <= '0;
         end else begin
            if (div_hit)                      div_sh[ch] <= bus_wdata[DIV_FIELD_STEP*ch +: PRE_W];
            if (wr_en && (bus_addr == PER_A)) per_sh[ch] <= bus_wdata[CNT_W-1:0];
            if (wr_en && (bus_addr == HI_A))  hi_sh[ch]  <= bus_wdata[CNT_W-1:0];
         end
      end

      // staging bit is taken from before the write that raises the trigger
      assign trig_rise   = ctrl_hit & bus_wdata[CTL_TRIG_LSB+ch] & ~ctrl_q[CTL_TRIG_LSB+ch];
      assign c_now[ch]   = trig_rise & ~ctrl_q[CTL_STAGE_LSB+ch];
      assign c_defer[ch] = trig_rise &  ctrl_q[CTL_STAGE_LSB+ch];

      pwm_stage_chan #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chan (
         .clk         (clk),
         .rst_n       (rst_n),
         .sh_pre      (div_sh[ch]),
         .sh_per      (per_sh[ch]),
         .sh_hi       (hi_sh[ch]),
         .pol         (ctrl_q[CTL_POL_LSB+ch]),
         .mode        (ctrl_q[CTL_MODE_LSB+ch]),
         .commit_now  (c_now[ch]),
         .commit_defer(c_defer[ch]),
         .pwm_out     (pwm_out[ch])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_we) begin
         if (bus_addr == ADDR_W'(MAP_CTRL)) bus_rdata = ctrl_q;
         if (bus_addr == ADDR_W'(MAP_DIV)) begin
            for (int i = 0; i < CHANNELS; i++)
               bus_rdata[DIV_FIELD_STEP*i +: PRE_W] = div_sh[i];
         end
         for (int i = 0; i < CHANNELS; i++) begin
            if (bus_addr == ADDR_W'(MAP_CH_BASE + MAP_CH_STRIDE * i))
               bus_rdata = 32'(per_sh[i]);
            if (bus_addr == ADDR_W'(MAP_CH_BASE + MAP_CH_STRIDE * i + MAP_HI_OFS))
               bus_rdata = 32'(hi_sh[i]);
         end
      end
   end

   AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q & ~CTRL_MASK) == 32'd0); // R2
endmodule

// File: tb/tb_pwm_stage_top.sv
module tb_pwm_stage_top;
   timeunit 1ns;
   timeprecision 1ps;

   typedef struct packed {
      logic        pol;
      logic [2:0]  pre;
      logic [23:0] per;
      logic [23:0] hi;
   } cfg_t;
   typedef struct packed {
      logic [2:0] ch;
      cfg_t       cfg;
   } vec_t;

   localparam int BIG = 32'h7fff_ffff;
   localparam vec_t VECS [6] = '{
      '{3'd0, '{1'b1, 3'd0, 24'd5, 24'd2}},
      '{3'd1, '{1'b0, 3'd1, 24'd4, 24'd1}},
      '{3'd2, '{1'b1, 3'd2, 24'd3, 24'd3}},
      '{3'd3, '{1'b1, 3'd0, 24'd6, 24'd0}},
      '{3'd4, '{1'b0, 3'd7, 24'd2, 24'd1}},
      '{3'd5, '{1'b0, 3'd0, 24'd8, 24'd9}}
   };

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [5:0]  pwm_out;

   int checks = 0, fails = 0, cyc = 0;
   bit finished = 0;
   logic [31:0] ctrl_sh = '0, div_sh = '0, rdv;
   cfg_t cur [6];
   int   cst [6];

   pwm_stage_top dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwm_out(pwm_out)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic lvl(input cfg_t c, input int j, input bit os);
      int p, cn;
      p = int'(c.pre) + 1;
      if (int'(c.per) < 2) return !c.pol;
      if (os && j >= int'(c.per) * p) return !c.pol;
      cn = (j / p) % int'(c.per);
      return (cn < int'(c.hi)) ? c.pol : !c.pol;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   // compare one pin each cycle; old settings before edge e, new from e
   task automatic win(input int ch, input int n, input int c0, input cfg_t a0,
                      input int e, input cfg_t a1, input bit os1, input string tag);
      int bad, k, bk;
      logic want, got, bw, bg;
      bad = 0; bk = 0; bw = 0; bg = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         k = cyc;
         want = (k - 1 < e) ? lvl(a0, k - 1 - c0, 1'b0) : lvl(a1, k - 1 - e, os1);
         got = pwm_out[ch];
         if (got !== want) begin
            if (bad == 0) begin bk = k; bw = want; bg = got; end
            bad++;
         end
      end
      checks++;
      if (bad != 0) begin
         fails++;
         $display("FAIL %s ch%0d edge %0d actual=%b expected=%b (%0d mismatches)",
                  tag, ch, bk, bg, bw, bad);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      cfg_t nc;
      int a, e, c, L;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      chk("R1 pins", 32'(pwm_out), 32'h3f);
      rd(8'h00, rdv); chk("R1 ctrl", rdv, 0);
      rd(8'h04, rdv); chk("R1 div", rdv, 0);
      rd(8'h20, rdv); chk("R1 period ch3", rdv, 0);
      rd(8'h34, rdv); chk("R1 high ch5", rdv, 0);

      // R2 readback masking
      wr(8'h00, 32'hffff_ffff); rd(8'h00, rdv); chk("R2 ctrl mask", rdv, 32'h3f3f_3f3f);
      wr(8'h04, 32'hffff_ffff); rd(8'h04, rdv); chk("R2 div mask", rdv, 32'h0077_7777);
      wr(8'h18, 32'hffff_ffff); rd(8'h18, rdv); chk("R2 period width", rdv, 32'h00ff_ffff);
      rd(8'h40, rdv); chk("R2 unmapped", rdv, 0);
      wr(8'h18, 0); wr(8'h04, 0); wr(8'h00, 0);

      // table: R3 R4 R6 plus R5/R8 before commit
      foreach (VECS[v]) begin
         int ch;
         ch = int'(VECS[v].ch);
         nc = VECS[v].cfg;
         ctrl_sh[8+ch] = nc.pol; ctrl_sh[16+ch] = 1'b1;
         ctrl_sh[ch] = 1'b0;     ctrl_sh[24+ch] = 1'b0;
         wr(8'h00, ctrl_sh);
         div_sh[4*ch +: 3] = nc.pre;
         wr(8'h04, div_sh);
         wr(8'(8 + 8*ch), 32'(nc.per));
         wr(8'(12 + 8*ch), 32'(nc.hi));
         repeat (3) @(negedge clk);
         chk("R5 R8 uncommitted idle pin", 32'(pwm_out[ch]), 32'(!nc.pol));
         ctrl_sh[ch] = 1'b1;
         wr(8'h00, ctrl_sh);
         c = cyc; cur[ch] = nc; cst[ch] = c;
         L = int'(nc.per) * (int'(nc.pre) + 1);
         win(ch, 2*L + 3, c, nc, c, nc, 1'b0, "R3 R4 R6 vector");
      end

      // R7 staged commit on running ch0 (period 5, divider 0)
      ctrl_sh[24] = 1'b1; ctrl_sh[0] = 1'b0; wr(8'h00, ctrl_sh);
      wr(8'h08, 7); wr(8'h0c, 4);
      nc = '{1'b1, 3'd0, 24'd7, 24'd4};
      ctrl_sh[24] = 1'b0; ctrl_sh[0] = 1'b1; wr(8'h00, ctrl_sh);
      a = cyc; L = 5;
      e = a + ((L - ((a - cst[0]) % L)) % L);
      win(0, (e - a) + 16, cst[0], cur[0], e, nc, 1'b0, "R7 staged boundary");
      cur[0] = nc; cst[0] = e;

      // R10 trigger rewritten as 1: no commit even with new shadow period
      wr(8'h08, 3);
      wr(8'h00, ctrl_sh);
      win(0, 20, cst[0], cur[0], BIG, cur[0], 1'b0, "R10 no re-commit");

      // R8 staged disable on ch1, then staged commit into idle channel
      ctrl_sh[25] = 1'b1; ctrl_sh[1] = 1'b0; wr(8'h00, ctrl_sh);
      wr(8'h10, 0); wr(8'h14, 0);
      ctrl_sh[25] = 1'b0; ctrl_sh[1] = 1'b1; wr(8'h00, ctrl_sh);
      a = cyc; L = 8;
      e = a + ((L - ((a - cst[1]) % L)) % L);
      nc = '{1'b0, 3'd1, 24'd0, 24'd0};
      win(1, (e - a) + 6, cst[1], cur[1], e, nc, 1'b0, "R8 disable via staged commit");
      ctrl_sh[25] = 1'b1; ctrl_sh[1] = 1'b0; wr(8'h00, ctrl_sh);
      wr(8'h10, 4); wr(8'h14, 2);
      ctrl_sh[25] = 1'b0; ctrl_sh[1] = 1'b1; wr(8'h00, ctrl_sh);
      a = cyc;
      nc = '{1'b0, 3'd1, 24'd4, 24'd2};
      win(1, 19, a, nc, a, nc, 1'b0, "R8 staged commit on idle applies at once");

      // R9 single-period mode on ch5
      ctrl_sh[5] = 1'b0; ctrl_sh[21] = 1'b0; ctrl_sh[13] = 1'b1; wr(8'h00, ctrl_sh);
      wr(8'h30, 4); wr(8'h34, 1);
      ctrl_sh[5] = 1'b1; wr(8'h00, ctrl_sh);
      c = cyc;
      nc = '{1'b1, 3'd0, 24'd4, 24'd1};
      win(5, 12, c, nc, c, nc, 1'b1, "R9 single period then inactive");

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule